// File: doc/BRIEF.md
# External Memory Bus Decoder and Arbiter

This block shares one external memory bus between three requesters: the CPU, the video engine and the audio engine. When the bus is idle it picks one pending request using a fixed priority that a configuration code selects. It drives the chosen requester's address onto the bus and asserts either the ROM chip select or the RAM chip select. The choice follows a 12-bit configuration word. The same word sets the number of wait states and an external clock enable. The memory devices and the data path are outside this block.

Each requester has a valid/ready style handshake. A requester raises `req_vld[i]` with a stable `req_addr` slice and must hold both until it sees `req_rdy[i]` high at a clock edge. That edge completes the access, and the requester may drop or change its request only after it. A requester that never sees ready simply stays pending: back-pressure is applied by withholding `req_rdy`. `gnt[i]` shows which requester owns the bus for the whole access. The bus spans `2**ADDR_W` addresses. Addresses below 0x4000 are internal and never select an external device.

Top module: `extbus_ctrl`

## Requirements
- R1: After reset, `gnt`, `req_rdy`, `rom_cs` and `ram_cs` are all zero and `bus_addr` is zero.
- R2: When the bus is idle and at least one `req_vld` bit is high at a clock edge, exactly one requester is granted from that edge onward. `bus_addr` then equals that requester's address. At most one `gnt` bit is ever high.
- R3: Arbitration code `cfg[5:3]` = 3'b111 ranks requesters as video (index 1), then audio (index 2), then CPU (index 0).
- R4: Arbitration code 3'b101 ranks audio, then video, then CPU. Every other code uses this same order.
- R5: An access holds its grant and chip select for 1+N cycles, with N = `cfg[2:1]`. `req_rdy` is high only for the granted requester and only in the last of those cycles.
- R6: An access in progress is never pre-empted. After its last cycle the bus spends exactly one idle cycle before the next grant.
- R7: An address below 0x4000 asserts neither chip select.
- R8: ROM decode is set by `cfg[7:6]`. With 00, every address from 0x4000 upward selects ROM. With 01, only addresses below `2**(ADDR_W-1)` select ROM. With 1x, only addresses below `2**(ADDR_W-2)` select ROM.
- R9: RAM decode is set by `cfg[11:8]`. If `cfg[11]` is 0, no RAM is mapped. Otherwise, with k = `cfg[10:8]`, RAM is the top `2**(ADDR_W-1-k)` addresses of the space.
- R10: Inside a RAM window the RAM select wins, and ROM is not selected. The two selects are never high together.
- R11: `clk_oe` always equals `cfg[0]`.
- R12: The decode results and wait count are captured at the grant edge. Changing `cfg` during an access does not alter that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg | input | 12 | Configuration word (RAM map, ROM map, arbitration, wait states, clock enable) |
| req_vld | input | 3 | Request per requester: 0 CPU, 1 video, 2 audio |
| req_addr | input | 3*ADDR_W | Request addresses, requester i at slice i |
| req_rdy | output | 3 | Access-complete pulse to the granted requester |
| gnt | output | 3 | One-hot bus owner |
| bus_addr | output | ADDR_W | Address driven to the external bus |
| rom_cs | output | 1 | ROM chip select, active high |
| ram_cs | output | 1 | RAM chip select, active high |
| clk_oe | output | 1 | External clock output enable |

## Verification
The bench builds the block with ADDR_W = 17. At that width the ROM windows are 0x4000–0x1FFFF, below 0x10000 and below 0x8000. The RAM windows range from the upper 64K down to the top 512 addresses. Because of this, every ROM code, the smallest and largest RAM windows and their overlap can all be reached with short hand-picked addresses. A behavioural model compares every output on every cycle. It does so while requests collide, while a higher-priority request arrives mid-access, and while the configuration changes mid-access.

// File: rtl/extbus_pkg.sv
package extbus_pkg;
  localparam int NM      = 3;
  localparam int M_CPU   = 0;
  localparam int M_VID   = 1;
  localparam int M_AUD   = 2;
  localparam int CFG_W   = 12;
  localparam int WS_W    = 2;

  typedef struct packed {
    logic       ram_on;
    logic [2:0] ram_k;
    logic [1:0] rom_mode;
    logic [2:0] arb_code;
    logic [1:0] wait_n;
    logic       clk_en;
  } cfg_t;

  typedef int unsigned rank_t [NM];

  function automatic rank_t prio_list(input logic [2:0] code);
    rank_t r;
    if (code == 3'b111) begin
      r[0] = M_VID; r[1] = M_AUD; r[2] = M_CPU;
    end else begin
      r[0] = M_AUD; r[1] = M_VID; r[2] = M_CPU;
    end
    return r;
  endfunction
endpackage

// File: rtl/extbus_arb.sv
module extbus_arb
  import extbus_pkg::*;
#(
  parameter int N = NM
) (
  input  logic [N-1:0] req,
  input  logic [2:0]   code,
  output logic [N-1:0] win,
  output logic         any
);
  rank_t order;
  logic  found;

  always_comb begin
    order = prio_list(code);
    win   = '0;
    found = 1'b0;
    for (int p = 0; p < N; p++) begin
      if (!found && req[order[p]]) begin
        win[order[p]] = 1'b1;
        found         = 1'b1;
      end
    end
    any = found;
  end
endmodule

// File: rtl/extbus_dec.sv
module extbus_dec #(
  parameter int ADDR_W   = 22,
  parameter int EXT_BASE = 'h4000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              ram_on,
  input  logic [2:0]        ram_k,
  input  logic [1:0]        rom_mode,
  output logic              rom_hit,
  output logic              ram_hit
);
  localparam logic [ADDR_W-1:0] BASE  = ADDR_W'(EXT_BASE);
  localparam logic [ADDR_W-1:0] HALF  = {1'b1, {(ADDR_W-1){1'b0}}};
  localparam logic [ADDR_W-1:0] QUART = {2'b01, {(ADDR_W-2){1'b0}}};

  logic              ext;
  logic [ADDR_W-1:0] ram_size;
  logic [ADDR_W-1:0] ram_lo;
  logic              rom_win;

  always_comb begin
    ext      = (addr >= BASE);
    ram_size = HALF >> ram_k;
    ram_lo   = ~(ram_size - 1'b1);
    ram_hit  = ext && ram_on && (addr >= ram_lo);
    unique case (rom_mode)
      2'b00:   rom_win = 1'b1;
      2'b01:   rom_win = (addr < HALF);
      default: rom_win = (addr < QUART);
    endcase
    rom_hit  = ext && rom_win && !ram_hit;
  end
endmodule

// File: rtl/extbus_seq.sv
module extbus_seq
  import extbus_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int N      = NM
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any,
  input  logic [N-1:0]      win,
  input  logic [ADDR_W-1:0] sel_addr,
  input  logic              rom_hit,
  input  logic              ram_hit,
  input  logic [WS_W-1:0]   wait_n,
  output logic [N-1:0]      gnt,
  output logic [N-1:0]      rdy,
  output logic              rom_cs,
  output logic              ram_cs,
  output logic [ADDR_W-1:0] bus_addr
);
  logic [WS_W-1:0] cnt;
  logic            busy;

  assign busy = |gnt;
  assign rdy  = gnt & {N{cnt == '0}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt      <= '0;
      cnt      <= '0;
      rom_cs   <= 1'b0;
      ram_cs   <= 1'b0;
      bus_addr <= '0;
    end else if (busy) begin
      if (cnt == '0) begin
        gnt      <= '0;
        rom_cs   <= 1'b0;
        ram_cs   <= 1'b0;
        bus_addr <= '0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else if (any) begin
      gnt      <= win;
      cnt      <= wait_n;
      rom_cs   <= rom_hit;
      ram_cs   <= ram_hit;
      bus_addr <= sel_addr;
    end
  end
endmodule

// File: rtl/extbus_ctrl.sv
module extbus_ctrl
  import extbus_pkg::*;
#(
  parameter int ADDR_W   = 22,
  parameter int EXT_BASE = 'h4000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CFG_W-1:0]     cfg,
  input  logic [NM-1:0]        req_vld,
  input  logic [NM*ADDR_W-1:0] req_addr,
  output logic [NM-1:0]        req_rdy,
  output logic [NM-1:0]        gnt,
  output logic [ADDR_W-1:0]    bus_addr,
  output logic                 rom_cs,
  output logic                 ram_cs,
  output logic                 clk_oe
);
  cfg_t              c;
  logic [NM-1:0]     win;
  logic              any;
  logic [ADDR_W-1:0] sel_addr;
  logic              rom_hit;
  logic              ram_hit;

  assign c      = cfg_t'(cfg);
  assign clk_oe = c.clk_en;

  extbus_arb #(.N(NM)) u_arb (
    .req  (req_vld),
    .code (c.arb_code),
    .win  (win),
    .any  (any)
  );

  always_comb begin
    sel_addr = '0;
    for (int i = 0; i < NM; i++)
      if (win[i]) sel_addr = req_addr[i*ADDR_W +: ADDR_W];
  end

  extbus_dec #(.ADDR_W(ADDR_W), .EXT_BASE(EXT_BASE)) u_dec (
    .addr     (sel_addr),
    .ram_on   (c.ram_on),
    .ram_k    (c.ram_k),
    .rom_mode (c.rom_mode),
    .rom_hit  (rom_hit),
    .ram_hit  (ram_hit)
  );

  extbus_seq #(.ADDR_W(ADDR_W), .N(NM)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .any      (any),
    .win      (win),
    .sel_addr (sel_addr),
    .rom_hit  (rom_hit),
    .ram_hit  (ram_hit),
    .wait_n   (c.wait_n),
    .gnt      (gnt),
    .rdy      (req_rdy),
    .rom_cs   (rom_cs),
    .ram_cs   (ram_cs),
    .bus_addr (bus_addr)
  );
endmodule

// File: rtl/extbus_ctrl_chk.sv
module extbus_ctrl_chk #(
  parameter int ADDR_W   = 22,
  parameter int EXT_BASE = 'h4000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        req_vld,
  input logic [2:0]        gnt,
  input logic [2:0]        req_rdy,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              rom_cs,
  input logic              ram_cs
);
  assert_onehot_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  assert_grant_to_requester_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gnt) && !(|$past(gnt))) |-> ((gnt & $past(req_vld)) == gnt));

  assert_ready_only_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rdy & ~gnt) == 3'b000);

  assert_select_needs_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_cs || ram_cs) |-> (|gnt));

  assert_no_preempt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gnt) && !(|req_rdy)) |=> (gnt == $past(gnt)));

  assert_idle_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_rdy) |=> (gnt == 3'b000));

  assert_internal_no_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gnt) && (bus_addr < ADDR_W'(EXT_BASE))) |-> (!rom_cs && !ram_cs));

  assert_selects_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_cs && ram_cs));

  assert_addr_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gnt) && !(|req_rdy)) |=> $stable(bus_addr));
endmodule

bind extbus_ctrl extbus_ctrl_chk #(.ADDR_W(ADDR_W), .EXT_BASE(EXT_BASE)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_vld  (req_vld),
  .gnt      (gnt),
  .req_rdy  (req_rdy),
  .bus_addr (bus_addr),
  .rom_cs   (rom_cs),
  .ram_cs   (ram_cs)
);

// File: tb/tb_extbus_ctrl.sv
`timescale 1ns/1ps
module tb_extbus_ctrl;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [11:0]   cfg = '0;
  logic [2:0]    req_vld = '0;
  logic [3*AW-1:0] req_addr = '0;
  logic [2:0]    req_rdy, gnt;
  logic [AW-1:0] bus_addr;
  logic          rom_cs, ram_cs, clk_oe;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  extbus_ctrl #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .req_vld(req_vld), .req_addr(req_addr),
    .req_rdy(req_rdy), .gnt(gnt), .bus_addr(bus_addr), .rom_cs(rom_cs),
    .ram_cs(ram_cs), .clk_oe(clk_oe)
  );

  // behavioural reference model
  bit m_busy;
  int m_owner;
  int m_cnt;
  bit m_rom, m_ram;
  int m_addr;

  function automatic int pick(input logic [2:0] r, input logic [2:0] code);
    int ord[3];
    if (code == 3'b111) begin ord[0] = 1; ord[1] = 2; ord[2] = 0; end
    else                begin ord[0] = 2; ord[1] = 1; ord[2] = 0; end
    foreach (ord[p]) if (r[ord[p]]) return ord[p];
    return -1;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_busy = 0; m_owner = 0; m_cnt = 0; m_rom = 0; m_ram = 0; m_addr = 0;
    end else if (m_busy) begin
      if (m_cnt == 0) begin
        m_busy = 0; m_rom = 0; m_ram = 0; m_addr = 0;
      end else m_cnt--;
    end else begin
      int w;
      w = pick(req_vld, cfg[5:3]);
      if (w >= 0) begin
        int a, k;
        bit ext;
        a = int'(req_addr[w*AW +: AW]);
        k = int'(cfg[10:8]);
        ext = a >= 'h4000;
        m_busy = 1; m_owner = w; m_cnt = int'(cfg[2:1]); m_addr = a;
        m_ram = ext && cfg[11] && (a >= (1 << 17) - ((1 << 16) >> k));
        case (cfg[7:6])
          2'b00:   m_rom = ext;
          2'b01:   m_rom = ext && (a < 'h10000);
          default: m_rom = ext && (a < 'h8000);
        endcase
        if (m_ram) m_rom = 0;
      end
    end
  end

  task automatic chk(input string r, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s (%s) t=%0t actual=%0h expected=%0h", r, tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic [2:0] eg;
      eg = m_busy ? (3'b001 << m_owner) : 3'b000;
      chk("R2 gnt", int'(gnt), int'(eg));
      chk("R5 rdy", int'(req_rdy), (m_busy && m_cnt == 0) ? int'(eg) : 0);
      chk("R8 rom_cs", int'(rom_cs), int'(m_rom));
      chk("R9 ram_cs", int'(ram_cs), int'(m_ram));
      chk("R2 bus_addr", int'(bus_addr), m_addr);
      chk("R11 clk_oe", int'(clk_oe), int'(cfg[0]));
    end
  end

  function automatic logic [11:0] mk(input logic [3:0] ram, input logic [1:0] rom,
                                     input logic [2:0] arb, input logic [1:0] ws, input logic oe);
    return {ram, rom, arb, ws, oe};
  endfunction

  // issue requests; at step 2 optionally change cfg and add late requests
  task automatic run(input string t, input logic [11:0] c0, input logic [2:0] mask,
                     input int a0, input int a1, input int a2,
                     input logic [11:0] cmid, input logic [2:0] late);
    logic [2:0] seen;
    int n;
    tag = t;
    @(negedge clk);
    cfg = c0;
    req_addr = {AW'(a2), AW'(a1), AW'(a0)};
    req_vld = mask;
    seen = '0;
    n = 0;
    while (req_vld != 0 && n < 200) begin
      @(negedge clk);
      req_vld = req_vld & ~seen;
      seen = req_rdy;
      n++;
      if (n == 2) begin
        cfg = cmid;
        req_vld = req_vld | late;
      end
    end
    if (n >= 200) begin
      total++; bad++;
      $display("FAIL %s run stuck actual=%0b expected=0", t, req_vld);
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 gnt", int'(gnt), 0);
    chk("R1 rdy", int'(req_rdy), 0);
    chk("R1 cs", int'({rom_cs, ram_cs}), 0);
    chk("R1 bus_addr", int'(bus_addr), 0);
    rst_n = 1'b1;

    run("R2 single", mk(4'h0, 2'b00, 3'b101, 2'd0, 1'b0), 3'b001, 'h5000, 0, 0,
        mk(4'h0, 2'b00, 3'b101, 2'd0, 1'b0), 3'b000);
    run("R4 code101 order", mk(4'h0, 2'b00, 3'b101, 2'd1, 1'b1), 3'b111, 'h4100, 'h4200, 'h4300,
        mk(4'h0, 2'b00, 3'b101, 2'd1, 1'b1), 3'b000);
    run("R3 code111 order", mk(4'h0, 2'b00, 3'b111, 2'd2, 1'b0), 3'b111, 'h6000, 'h7000, 'h8000,
        mk(4'h0, 2'b00, 3'b111, 2'd2, 1'b0), 3'b000);
    run("R4 fallback code000", mk(4'h0, 2'b00, 3'b000, 2'd0, 1'b1), 3'b111, 'h4000, 'h4001, 'h4002,
        mk(4'h0, 2'b00, 3'b000, 2'd0, 1'b1), 3'b000);
    run("R6 late higher request", mk(4'h0, 2'b00, 3'b101, 2'd3, 1'b0), 3'b001, 'h5000, 'h5004, 'h5008,
        mk(4'h0, 2'b00, 3'b101, 2'd3, 1'b0), 3'b110);
    run("R7 internal addr", mk(4'h8, 2'b00, 3'b101, 2'd1, 1'b0), 3'b011, 'h1000, 'h3FFF, 0,
        mk(4'h8, 2'b00, 3'b101, 2'd1, 1'b0), 3'b000);
    run("R8 rom mode01", mk(4'h0, 2'b01, 3'b101, 2'd0, 1'b0), 3'b111, 'h12000, 'h9000, 'hFFFF,
        mk(4'h0, 2'b01, 3'b101, 2'd0, 1'b0), 3'b000);
    run("R8 rom mode1x", mk(4'h0, 2'b10, 3'b111, 2'd0, 1'b0), 3'b111, 'h9000, 'h6000, 'h7FFF,
        mk(4'h0, 2'b11, 3'b111, 2'd0, 1'b0), 3'b000);
    run("R9 ram largest", mk(4'h8, 2'b01, 3'b101, 2'd1, 1'b0), 3'b111, 'h18000, 'h10000, 'hFFFF,
        mk(4'h8, 2'b01, 3'b101, 2'd1, 1'b0), 3'b000);
    run("R9 ram smallest", mk(4'hF, 2'b00, 3'b101, 2'd0, 1'b1), 3'b111, 'h1FF80, 'h1FE00, 'h1FF00,
        mk(4'hF, 2'b00, 3'b101, 2'd0, 1'b1), 3'b000);
    run("R9 ram off bit11", mk(4'h7, 2'b00, 3'b101, 2'd0, 1'b0), 3'b001, 'h1FFFF, 0, 0,
        mk(4'h7, 2'b00, 3'b101, 2'd0, 1'b0), 3'b000);
    run("R10 ram over rom", mk(4'hC, 2'b00, 3'b111, 2'd2, 1'b0), 3'b111, 'h1F000, 'h1E000, 'h14000,
        mk(4'hC, 2'b00, 3'b111, 2'd2, 1'b0), 3'b000);
    run("R12 cfg change mid access", mk(4'h0, 2'b00, 3'b101, 2'd3, 1'b0), 3'b001, 'h1C000, 0, 0,
        mk(4'h8, 2'b10, 3'b111, 2'd0, 1'b1), 3'b000);
    run("R12 after change", mk(4'h8, 2'b10, 3'b111, 2'd0, 1'b1), 3'b110, 0, 'h1C000, 'h5000,
        mk(4'h0, 2'b00, 3'b101, 2'd2, 1'b0), 3'b000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected<20000", cycles);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule